// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block follows a processor package through its nested low-power states. It starts in Stop-Grant. From there it can go down to Sleep, then to Deep Sleep, and then to one of two Deeper Sleep variants. The move to each deeper level happens only from the level directly above it, on a level change of an active-low request pin. It climbs back out through the same levels in reverse order. The sequencer drives four things from its state:
- a 7-bit voltage identification code for the core regulator
- a permission that lets the clock generator stop the reference clock
- snoop-ready and interrupt-ready indications for the rest of the package

States and transitions (the `pstate` code is shown in brackets):
- STOPGNT [0] to SLEEP [1] when `slp_n` falls. SLEEP to STOPGNT when `slp_n` rises.
- SLEEP to DSLP [2] when `dslp_n` is low.
- DSLP to DPRS [4] when `dstop_n` is low and `l2_off` is 0. DSLP to DPRS_ENH [5] when `dstop_n` is low and `l2_off` is 1.
- DPRS or DPRS_ENH back to DSLP when `dstop_n` rises.
- DSLP to RELOCK [3] when `dslp_n` rises. RELOCK back to DSLP if `dslp_n` falls again.
- RELOCK to SLEEP once the PLL settling time has been counted on `us_tick`.

While in RELOCK, the block also expects the reference clock to come back within a fixed number of cycles. Each observed clock edge is reported on `ref_edge`. A sticky protocol error is raised in two cases: when inputs move in a way the deep states forbid, or when the clock does not return in time.

Top module: `lp_state_seq`

## Requirements
- R1: During and right after reset, the outputs are: `pstate`=0 (STOPGNT), `vid`=VID_NOM (default 7'h30), `clk_stop_ok`=0, `snoop_rdy`=1, `intr_rdy`=1 and `proto_err`=0.
- R2: In STOPGNT, a low `slp_n` moves the block to SLEEP (`pstate`=1) on the next clock. In SLEEP, a high `slp_n` returns it to STOPGNT (`pstate`=0).
- R3: A low `dslp_n` or a low `dstop_n` while in STOPGNT has no effect on any output.
- R4: In SLEEP with `slp_n` low, a low `dslp_n` moves the block to DSLP (`pstate`=2).
- R5: In DSLP, a low `dstop_n` moves the block to DPRS (`pstate`=4) when `l2_off`=0, and to DPRS_ENH (`pstate`=5) when `l2_off`=1. This move takes priority over a release of `dslp_n` in the same cycle.
- R6: In DPRS or DPRS_ENH, a high `dstop_n` returns the block to DSLP (`pstate`=2).
- R7: `vid` is VID_DPRS (default 7'h20) in DPRS, VID_ENH (default 7'h18) in DPRS_ENH, and VID_NOM in every other state.
- R8: In DSLP, a high `dslp_n` moves the block to RELOCK (`pstate`=3). The block stays in RELOCK until the RELOCK_US-th `us_tick` pulse (default 15) counted there, and then moves to SLEEP. A low `dslp_n` during RELOCK returns the block to DSLP, and the count starts again from zero on the next RELOCK.
- R9: `clk_stop_ok` is 1 only in DSLP, DPRS and DPRS_ENH.
- R10: `snoop_rdy` and `intr_rdy` are 1 only in STOPGNT and SLEEP.
- R11: In DSLP, DPRS or DPRS_ENH, a change of `slp_n` sets `proto_err` and does not change the state. In DPRS or DPRS_ENH, a change of `dslp_n` does the same. `proto_err` then stays set until `err_clr` is high in a cycle with no new error.
- R12: If `ref_edge` is not seen during the first RESUME_CYC cycles in RELOCK (default 10), `proto_err` is set on the clock after the last cycle of that window. An edge seen in the last cycle of the window avoids the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_n | input | 1 | Sleep request, active low |
| dslp_n | input | 1 | Deep-sleep request, active low |
| dstop_n | input | 1 | Deeper-stop request, active low |
| l2_off | input | 1 | L2 cache fully shut down |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| ref_edge | input | 1 | Pulse when a reference clock edge is observed |
| err_clr | input | 1 | Clears the sticky error flag |
| vid | output | 7 | Voltage identification code |
| clk_stop_ok | output | 1 | Reference clock may be stopped |
| snoop_rdy | output | 1 | Package can answer snoops |
| intr_rdy | output | 1 | Package can latch interrupts |
| proto_err | output | 1 | Sticky illegal-activity / clock-timeout flag |
| pstate | output | 3 | Current state code |

## Verification
A table of single-cycle pin patterns walks the full descent and climb. Along the way it presents requests that have no effect in STOPGNT, and it takes the deeper-stop branch once with the cache flag clear and once with it set. This shows that the level is chosen correctly, and that the voltage code matches that level. A RELOCK that is interrupted and then restarted shows that the settling count restarts. Fourteen and then fifteen microsecond ticks show exactly where the count ends. Three further patterns tell apart a legal exit from an illegal pin change: a sleep-pin toggle in Deep Sleep, a deep-sleep-pin toggle in Deeper Sleep, and a clock-return pulse in the last cycle of the window compared with no pulse at all.

// File: rtl/lps_pkg.sv
package lps_pkg;
    typedef enum logic [2:0] {
        ST_STOPGNT  = 3'd0,
        ST_SLEEP    = 3'd1,
        ST_DSLP     = 3'd2,
        ST_RELOCK   = 3'd3,
        ST_DPRS     = 3'd4,
        ST_DPRS_ENH = 3'd5
    } lp_state_e;
endpackage

// File: rtl/lps_relock_timer.sv
module lps_relock_timer #(
    parameter int RELOCK_US = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(RELOCK_US + 1);
    logic [CW-1:0] cnt;

    assign done = run && tick && (cnt == CW'(RELOCK_US - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!run)        cnt <= '0;
        else if (tick && !done) cnt <= cnt + 1'b1;
    end

    // R8: the tick count never passes the settling limit
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(RELOCK_US));
endmodule

// File: rtl/lps_resume_watch.sv
module lps_resume_watch #(
    parameter int RESUME_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_edge,
    output logic tmo
);
    localparam int CW = $clog2(RESUME_CYC + 1);
    logic [CW-1:0] cnt;
    logic          settled;

    assign tmo = run && !settled && !ref_edge && (cnt == CW'(RESUME_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            settled <= 1'b0;
        end else if (!run) begin
            cnt     <= '0;
            settled <= 1'b0;
        end else if (!settled) begin
            if (ref_edge || tmo) settled <= 1'b1;
            else                 cnt <= cnt + 1'b1;
        end
    end

    // R12: at most one timeout pulse per stay in RELOCK
    a_r12_single_tmo: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> !tmo);
endmodule

// File: rtl/lps_err_mon.sv
module lps_err_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic in_deep,
    input  logic in_deeper,
    input  logic slp_n,
    input  logic dslp_n,
    input  logic tmo,
    input  logic clr,
    output logic err
);
    logic slp_q;
    logic dslp_q;
    logic hit;

    always_comb begin
        hit = tmo;
        if (in_deep && (slp_n != slp_q))     hit = 1'b1;
        if (in_deeper && (dslp_n != dslp_q)) hit = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slp_q  <= 1'b1;
            dslp_q <= 1'b1;
            err    <= 1'b0;
        end else begin
            slp_q  <= slp_n;
            dslp_q <= dslp_n;
            if (hit)      err <= 1'b1;
            else if (clr) err <= 1'b0;
        end
    end

    // R11: the flag holds until a clear arrives
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> err);
endmodule

// File: rtl/lp_state_seq.sv
module lp_state_seq
    import lps_pkg::*;
#(
    parameter logic [6:0] VID_NOM    = 7'h30,
    parameter logic [6:0] VID_DPRS   = 7'h20,
    parameter logic [6:0] VID_ENH    = 7'h18,
    parameter int         RELOCK_US  = 15,
    parameter int         RESUME_CYC = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slp_n,
    input  logic       dslp_n,
    input  logic       dstop_n,
    input  logic       l2_off,
    input  logic       us_tick,
    input  logic       ref_edge,
    input  logic       err_clr,
    output logic [6:0] vid,
    output logic       clk_stop_ok,
    output logic       snoop_rdy,
    output logic       intr_rdy,
    output logic       proto_err,
    output logic [2:0] pstate
);
    lp_state_e st, nxt;
    logic relock_done;
    logic resume_tmo;
    logic in_relock;
    logic in_deep;
    logic in_deeper;

    assign in_relock = (st == ST_RELOCK);
    assign in_deeper = (st == ST_DPRS) || (st == ST_DPRS_ENH);
    assign in_deep   = (st == ST_DSLP) || in_deeper;

    lps_relock_timer #(.RELOCK_US(RELOCK_US)) u_relock (
        .clk(clk), .rst_n(rst_n), .run(in_relock), .tick(us_tick), .done(relock_done)
    );

    lps_resume_watch #(.RESUME_CYC(RESUME_CYC)) u_resume (
        .clk(clk), .rst_n(rst_n), .run(in_relock), .ref_edge(ref_edge), .tmo(resume_tmo)
    );

    lps_err_mon u_err (
        .clk(clk), .rst_n(rst_n), .in_deep(in_deep), .in_deeper(in_deeper),
        .slp_n(slp_n), .dslp_n(dslp_n), .tmo(resume_tmo), .clr(err_clr), .err(proto_err)
    );

    always_comb begin
        nxt = st;
        unique case (st)
            ST_STOPGNT:  if (!slp_n) nxt = ST_SLEEP;
            ST_SLEEP: begin
                if (slp_n)        nxt = ST_STOPGNT;
                else if (!dslp_n) nxt = ST_DSLP;
            end
            ST_DSLP: begin
                if (!dstop_n)    nxt = l2_off ? ST_DPRS_ENH : ST_DPRS;
                else if (dslp_n) nxt = ST_RELOCK;
            end
            ST_RELOCK: begin
                if (!dslp_n)          nxt = ST_DSLP;
                else if (relock_done) nxt = ST_SLEEP;
            end
            ST_DPRS, ST_DPRS_ENH: if (dstop_n) nxt = ST_DSLP;
            default: nxt = ST_STOPGNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_STOPGNT;
        else        st <= nxt;
    end

    always_comb begin
        vid         = VID_NOM;
        clk_stop_ok = 1'b0;
        snoop_rdy   = 1'b0;
        intr_rdy    = 1'b0;
        unique case (st)
            ST_STOPGNT, ST_SLEEP: begin
                snoop_rdy = 1'b1;
                intr_rdy  = 1'b1;
            end
            ST_DSLP:     clk_stop_ok = 1'b1;
            ST_RELOCK:   ;
            ST_DPRS: begin
                vid         = VID_DPRS;
                clk_stop_ok = 1'b1;
            end
            ST_DPRS_ENH: begin
                vid         = VID_ENH;
                clk_stop_ok = 1'b1;
            end
            default: ;
        endcase
    end

    assign pstate = st;

    // R5: a Deeper level is reached only from Deep Sleep
    a_r5_deeper_from_dslp: assert property (@(posedge clk) disable iff (!rst_n)
        (in_deeper && !$past(in_deeper)) |-> ($past(st) == ST_DSLP));

    // R8: leaving RELOCK for Sleep needs a tick
    a_r8_exit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP && $past(st) == ST_RELOCK) |-> $past(us_tick));

    // R9: clock-stop permission appears only after Sleep or RELOCK
    a_r9_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stop_ok) |-> ($past(st) == ST_SLEEP || $past(st) == ST_RELOCK));

    // R10: never ready while the clock may be stopped
    a_r10_rdy_vs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_ok |-> (!snoop_rdy && !intr_rdy));

    // R2: Stop-Grant is left only towards Sleep
    a_r2_stopgnt_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_STOPGNT && st != ST_STOPGNT) |-> (st == ST_SLEEP));
endmodule

// File: tb/lp_state_seq_test.sv
module lp_state_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] V_NOM = 7'h30;
    localparam logic [6:0] V_DPRS = 7'h20;
    localparam logic [6:0] V_ENH = 7'h18;

    // row: [14:11] req, [10:4] {slp,dslp,dstop,l2,tick,ref,clr}, [3:1] state, [0] err
    localparam int NROWS = 14;
    localparam logic [14:0] VEC [NROWS] = '{
        {4'd3, 7'b1010000, 3'd0, 1'b0},  // R3 deep-sleep pin in STOPGNT ignored
        {4'd3, 7'b1100000, 3'd0, 1'b0},  // R3 deeper-stop in STOPGNT ignored
        {4'd2, 7'b0110000, 3'd1, 1'b0},  // R2 enter SLEEP
        {4'd2, 7'b1110000, 3'd0, 1'b0},  // R2 back to STOPGNT
        {4'd2, 7'b0110000, 3'd1, 1'b0},  // R2
        {4'd4, 7'b0010000, 3'd2, 1'b0},  // R4 enter DSLP
        {4'd5, 7'b0000000, 3'd4, 1'b0},  // R5 DPRS, cache not empty
        {4'd6, 7'b0010000, 3'd2, 1'b0},  // R6 back to DSLP
        {4'd5, 7'b0001000, 3'd5, 1'b0},  // R5 enhanced, cache empty
        {4'd6, 7'b0011000, 3'd2, 1'b0},  // R6
        {4'd8, 7'b0110000, 3'd3, 1'b0},  // R8 RELOCK
        {4'd8, 7'b0010000, 3'd2, 1'b0},  // R8 re-assert returns to DSLP
        {4'd8, 7'b0110000, 3'd3, 1'b0},  // R8 RELOCK again
        {4'd12, 7'b0110010, 3'd3, 1'b0}  // R12 clock back early
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slp_n = 1'b1, dslp_n = 1'b1, dstop_n = 1'b1, l2_off = 1'b0;
    logic us_tick = 1'b0, ref_edge = 1'b0, err_clr = 1'b0;
    logic [6:0] vid;
    logic clk_stop_ok, snoop_rdy, intr_rdy, proto_err;
    logic [2:0] pstate;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_state_seq uut (
        .clk(clk), .rst_n(rst_n), .slp_n(slp_n), .dslp_n(dslp_n), .dstop_n(dstop_n),
        .l2_off(l2_off), .us_tick(us_tick), .ref_edge(ref_edge), .err_clr(err_clr),
        .vid(vid), .clk_stop_ok(clk_stop_ok), .snoop_rdy(snoop_rdy), .intr_rdy(intr_rdy),
        .proto_err(proto_err), .pstate(pstate)
    );

    function automatic logic [13:0] expect_out(input logic [2:0] s, input logic e);
        logic [6:0] v;
        logic cs, rd;
        v  = (s == 3'd4) ? V_DPRS : (s == 3'd5) ? V_ENH : V_NOM;  // R7
        cs = (s == 3'd2) || (s == 3'd4) || (s == 3'd5);           // R9
        rd = (s == 3'd0) || (s == 3'd1);                          // R10
        return {s, v, cs, rd, rd, e};
    endfunction

    task automatic chk(input string req, input logic [2:0] s, input logic e);
        logic [13:0] act, exp;
        act = {pstate, vid, clk_stop_ok, snoop_rdy, intr_rdy, proto_err};
        exp = expect_out(s, e);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {pstate,vid,stop,snp,int,err} actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", 3'd0, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1 after reset", 3'd0, 1'b0);

        for (int i = 0; i < NROWS; i++) begin
            {slp_n, dslp_n, dstop_n, l2_off, us_tick, ref_edge, err_clr} = VEC[i][10:4];
            step();
            chk($sformatf("R%0d row %0d", VEC[i][14:11], i), VEC[i][3:1], VEC[i][0]);
        end
        ref_edge = 1'b0;

        // R8: 14 ticks keep RELOCK, the 15th leads to SLEEP
        us_tick = 1'b1;
        repeat (14) step();
        chk("R8 14 ticks", 3'd3, 1'b0);
        step();
        us_tick = 1'b0;
        chk("R8 15th tick", 3'd1, 1'b0);

        // R11: sleep pin toggled in DSLP
        dslp_n = 1'b0;
        step();
        chk("R4 DSLP again", 3'd2, 1'b0);
        slp_n = 1'b1;
        step();
        chk("R11 slp toggle in DSLP", 3'd2, 1'b1);
        slp_n = 1'b0;
        step();
        chk("R11 sticky", 3'd2, 1'b1);
        err_clr = 1'b1;
        step();
        err_clr = 1'b0;
        chk("R11 cleared", 3'd2, 1'b0);

        // R12: clock edge in the last cycle of the window
        dslp_n = 1'b1;
        repeat (10) step();
        ref_edge = 1'b1;
        step();
        ref_edge = 1'b0;
        step();
        chk("R12 edge at window end", 3'd3, 1'b0);
        dslp_n = 1'b0;
        step();
        chk("R8 back to DSLP", 3'd2, 1'b0);

        // R12: no clock edge at all
        dslp_n = 1'b1;
        repeat (10) step();
        chk("R12 window not yet over", 3'd3, 1'b0);
        step();
        chk("R12 timeout", 3'd3, 1'b1);
        err_clr = 1'b1;
        step();
        err_clr = 1'b0;
        chk("R11 clear after timeout", 3'd3, 1'b0);

        // R11: deep-sleep pin toggled in DPRS
        dslp_n = 1'b0;
        step();
        dstop_n = 1'b0;
        step();
        chk("R5 DPRS", 3'd4, 1'b0);
        dslp_n = 1'b1;
        step();
        chk("R11 dslp toggle in DPRS", 3'd4, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule